// File: doc/BRIEF.md
# Multiple-Precision Coprocessor Control Unit

This block sits at the front of a multiple-precision integer coprocessor. It reads a byte stream of instructions, puts together the opcode and register fields, and starts the unit that does the work: one of two loaders, the unloader, the multiplier or the adder-subtractor. The data path only ever sees magnitudes. The sign and the limb count of each of the sixteen logical numbers live here in the controller.

The controller translates every logical register number to one of seventeen physical limb stores. One spare physical store acts as the shadow. An add or subtract writes two candidate magnitudes, one into the destination and one into the shadow. When the adder reports that the shadow copy is the right one, the two physical indices trade places, so no data has to move. A busy scoreboard covers the physical stores, and a busy flag covers each unit. An instruction waits until every resource it names is free, and while it waits the program stream is held back.

Top module: `mpcu_ctrl`

## Requirements
- R1: After reset, prog_ready is high, no start strobe is active and overflow is low. Logical register i maps to physical i, and physical 16 is the shadow.
- R2: Byte 0 carries the opcode in bits 7:5 (0 nop, 1 load A, 2 load B, 3 load both, 4 unload, 5 multiply, 6 add, 7 subtract). Every opcode except nop is followed by a byte {X in 7:4, Y in 3:0}. Multiply, add and subtract take a third byte {Z in 7:4, 0}, where Z is the destination. A nop takes one byte and does nothing.
- R3: Load A and load B start their own loader with X's physical index. Load both starts loader A on X and loader B on Y in the same cycle. When a loader signals done, its sign and size are recorded for the logical register it loaded.
- R4: Unload starts the unloader with X's physical index, sign and limb count.
- R5: An instruction issues only when its unit is idle and none of the physical stores it names (including the shadow for add or subtract) is busy. Those stores remain busy until the unit signals done. Until the instruction issues, no further program byte is accepted.
- R6: A product takes the sign of X XOR the sign of Y. Its size is size(X)+size(Y), minus one when the multiplier flags a zero top limb.
- R7: Add and subtract use the effective sign of Y, which is sign(Y) inverted for subtract. as_sub_eff is high when this differs from sign(X). The sizes of X and Y are presented on opa_size and opb_size.
- R8: Result sign for add and subtract. When the signs agree, the result takes the sign of X. When they differ and the shadow is picked, it takes the effective sign of Y. When they differ and the shadow is not picked, it takes the sign of X. A zero-size result of any operation is positive.
- R9: When the signs differ and the adder picks the shadow, the destination's logical register takes the shadow's physical index and the old destination becomes the new shadow. When the signs agree, the pick bit is ignored. The shadow is never the destination of an add or subtract.
- R10: A result above MAX_LIMBS limbs sets a sticky overflow output and is recorded as MAX_LIMBS limbs.
- R11: Every start strobe lasts one cycle, and a unit is never restarted before it signals done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_valid | input | 1 | Program byte valid |
| prog_byte | input | 8 | Program byte |
| prog_ready | output | 1 | Controller accepts a byte |
| lda_start | output | 1 | Start loader A |
| lda_phys | output | 5 | Physical target of loader A |
| lda_done | input | 1 | Loader A finished |
| lda_sign | input | 1 | Sign from loader A header |
| lda_size | input | 10 | Limb count from loader A header |
| ldb_start | output | 1 | Start loader B |
| ldb_phys | output | 5 | Physical target of loader B |
| ldb_done | input | 1 | Loader B finished |
| ldb_sign | input | 1 | Sign from loader B header |
| ldb_size | input | 10 | Limb count from loader B header |
| unl_start | output | 1 | Start unloader |
| unl_phys | output | 5 | Physical source to unload |
| unl_sign | output | 1 | Sign of unloaded number |
| unl_size | output | 10 | Limb count of unloaded number |
| unl_done | input | 1 | Unloader finished |
| opa_size | output | 10 | Limb count of operand X |
| opb_size | output | 10 | Limb count of operand Y |
| mul_start | output | 1 | Start multiplier |
| mul_pa | output | 5 | Physical operand X |
| mul_pb | output | 5 | Physical operand Y |
| mul_pd | output | 5 | Physical destination |
| mul_done | input | 1 | Multiplier finished |
| mul_top_zero | input | 1 | Top product limb is zero |
| as_start | output | 1 | Start adder-subtractor |
| as_sub_eff | output | 1 | Magnitudes are subtracted |
| as_pa | output | 5 | Physical operand X |
| as_pb | output | 5 | Physical operand Y |
| as_pd | output | 5 | Physical destination |
| as_ps | output | 5 | Physical shadow |
| as_done | input | 1 | Adder-subtractor finished |
| as_pick_shadow | input | 1 | Shadow holds the valid result |
| as_res_size | input | 11 | Limb count of the valid result |
| overflow | output | 1 | Sticky result-overflow flag |

## Verification
A start strobe rises one cycle after the issue edge. For a load, multiply or add, the number's sign, size and mapping change at the clock edge that samples the unit's done, so an unload that depends on them can issue at the next edge at the earliest, and its strobe follows one cycle later. The bench samples every strobe and output at the falling edge. Expected unload headers are queued in program order, and the monitor compares each against the next unload strobe. Whatever order the stub latencies produce, every value is therefore checked in the cycle the controller presents it.

// File: rtl/mpcu_pkg.sv
package mpcu_pkg;

   localparam int LREG_W = 4;

   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_LDA  = 3'd1,
      OP_LDB  = 3'd2,
      OP_LDAB = 3'd3,
      OP_UNL  = 3'd4,
      OP_MUL  = 3'd5,
      OP_ADD  = 3'd6,
      OP_SUB  = 3'd7
   } op_e;

   typedef struct packed {
      op_e               op;
      logic [LREG_W-1:0] x;
      logic [LREG_W-1:0] y;
      logic [LREG_W-1:0] z;
   } ins_t;

   function automatic logic takes_three(input op_e op);
      return (op == OP_MUL) || (op == OP_ADD) || (op == OP_SUB);
   endfunction

endpackage

// File: rtl/mpcu_fetch.sv
module mpcu_fetch
   import mpcu_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        prog_valid,
   input  logic [7:0]  prog_byte,
   output logic        prog_ready,
   input  logic        take,
   output logic        ins_valid,
   output ins_t        ins
);

   logic [1:0] phase_q;
   logic       valid_q;
   ins_t       ins_q;
   op_e        op_in;

   assign prog_ready = !valid_q;
   assign ins_valid  = valid_q;
   assign ins        = ins_q;
   assign op_in      = op_e'(prog_byte[7:5]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 2'd0;
         valid_q <= 1'b0;
         ins_q   <= '0;
      end else begin
         if (take) valid_q <= 1'b0;
         if (prog_valid && !valid_q) begin
            case (phase_q)
               2'd0: begin
                  ins_q.op <= op_in;
                  if (op_in != OP_NOP) phase_q <= 2'd1;
               end
               2'd1: begin
                  ins_q.x <= prog_byte[7:4];
                  ins_q.y <= prog_byte[3:0];
                  if (takes_three(ins_q.op)) begin
                     phase_q <= 2'd2;
                  end else begin
                     phase_q <= 2'd0;
                     valid_q <= 1'b1;
                  end
               end
               default: begin
                  ins_q.z <= prog_byte[7:4];
                  phase_q <= 2'd0;
                  valid_q <= 1'b1;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/mpcu_regmap.sv
module mpcu_regmap
   import mpcu_pkg::*;
#(
   parameter int N_LOG = 16,
   parameter int PW    = 5,
   parameter int LW    = 10,
   parameter int NWR   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          swap_en,
   input  logic [LREG_W-1:0]             swap_l,
   input  logic [NWR-1:0]                wr_en,
   input  logic [NWR-1:0][LREG_W-1:0]    wr_l,
   input  logic [NWR-1:0]                wr_sgn,
   input  logic [NWR-1:0][LW-1:0]        wr_sz,
   output logic [N_LOG-1:0][PW-1:0]      map_o,
   output logic [PW-1:0]                 shadow_o,
   output logic [N_LOG-1:0]              sgn_o,
   output logic [N_LOG-1:0][LW-1:0]      sz_o
);

   logic [PW-1:0] shadow_q;
   assign shadow_o = shadow_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       shadow_q <= PW'(N_LOG);
      else if (swap_en) shadow_q <= map_o[swap_l];
   end

   for (genvar g = 0; g < N_LOG; g++) begin : g_lreg
      logic [PW-1:0] m_q;
      logic          s_q;
      logic [LW-1:0] z_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            m_q <= PW'(g);
            s_q <= 1'b0;
            z_q <= '0;
         end else begin
            if (swap_en && swap_l == LREG_W'(g)) m_q <= shadow_q;
            for (int k = 0; k < NWR; k++) begin
               if (wr_en[k] && wr_l[k] == LREG_W'(g)) begin
                  s_q <= wr_sgn[k];
                  z_q <= wr_sz[k];
               end
            end
         end
      end

      assign map_o[g] = m_q;
      assign sgn_o[g] = s_q;
      assign sz_o[g]  = z_q;
   end

endmodule

// File: rtl/mpcu_busy.sv
module mpcu_busy #(
   parameter int N_PHYS = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_PHYS-1:0] set_m,
   input  logic [N_PHYS-1:0] clr_m,
   output logic [N_PHYS-1:0] busy_o
);

   for (genvar i = 0; i < N_PHYS; i++) begin : g_bit
      logic b_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        b_q <= 1'b0;
         else if (set_m[i]) b_q <= 1'b1;
         else if (clr_m[i]) b_q <= 1'b0;
      end
      assign busy_o[i] = b_q;
   end

endmodule

// File: rtl/mpcu_ctrl.sv
module mpcu_ctrl
   import mpcu_pkg::*;
#(
   parameter int N_LOG     = 16,
   parameter int MAX_LIMBS = 512,
   localparam int N_PHYS   = N_LOG + 1,
   localparam int PW       = $clog2(N_PHYS),
   localparam int LW       = $clog2(MAX_LIMBS + 1),
   localparam int SW       = LW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          prog_valid,
   input  logic [7:0]    prog_byte,
   output logic          prog_ready,
   output logic          lda_start,
   output logic [PW-1:0] lda_phys,
   input  logic          lda_done,
   input  logic          lda_sign,
   input  logic [LW-1:0] lda_size,
   output logic          ldb_start,
   output logic [PW-1:0] ldb_phys,
   input  logic          ldb_done,
   input  logic          ldb_sign,
   input  logic [LW-1:0] ldb_size,
   output logic          unl_start,
   output logic [PW-1:0] unl_phys,
   output logic          unl_sign,
   output logic [LW-1:0] unl_size,
   input  logic          unl_done,
   output logic [LW-1:0] opa_size,
   output logic [LW-1:0] opb_size,
   output logic          mul_start,
   output logic [PW-1:0] mul_pa,
   output logic [PW-1:0] mul_pb,
   output logic [PW-1:0] mul_pd,
   input  logic          mul_done,
   input  logic          mul_top_zero,
   output logic          as_start,
   output logic          as_sub_eff,
   output logic [PW-1:0] as_pa,
   output logic [PW-1:0] as_pb,
   output logic [PW-1:0] as_pd,
   output logic [PW-1:0] as_ps,
   input  logic          as_done,
   input  logic          as_pick_shadow,
   input  logic [SW-1:0] as_res_size,
   output logic          overflow
);

   if (N_LOG != (1 << LREG_W)) begin : g_bad_nlog
      $error("mpcu_ctrl: N_LOG must match the 4-bit register fields");
   end
   if (MAX_LIMBS < 1) begin : g_bad_max
      $error("mpcu_ctrl: MAX_LIMBS must be positive");
   end

   function automatic logic [N_PHYS-1:0] oh(input logic [PW-1:0] p);
      return N_PHYS'(1) << p;
   endfunction

   // instruction assembly
   logic ins_valid, issue;
   ins_t ins;

   mpcu_fetch u_fetch (
      .clk(clk), .rst_n(rst_n), .prog_valid(prog_valid), .prog_byte(prog_byte),
      .prog_ready(prog_ready), .take(issue), .ins_valid(ins_valid), .ins(ins)
   );

   // mapping and metadata
   logic [N_LOG-1:0][PW-1:0] map_q;
   logic [PW-1:0]            shadow_q;
   logic [N_LOG-1:0]         sgn_q;
   logic [N_LOG-1:0][LW-1:0] sz_q;
   logic                     swap_en;
   logic [3:0]               wr_en, wr_sgn;
   logic [3:0][LREG_W-1:0]   wr_l;
   logic [3:0][LW-1:0]       wr_sz;

   mpcu_regmap #(.N_LOG(N_LOG), .PW(PW), .LW(LW), .NWR(4)) u_map (
      .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .swap_l(wr_l[3]),
      .wr_en(wr_en), .wr_l(wr_l), .wr_sgn(wr_sgn), .wr_sz(wr_sz),
      .map_o(map_q), .shadow_o(shadow_q), .sgn_o(sgn_q), .sz_o(sz_q)
   );

   // scoreboard
   logic [N_PHYS-1:0] busy, need, set_m, clr_m;
   logic [N_PHYS-1:0] lda_pm, ldb_pm, unl_pm, mul_pm, as_pm;

   mpcu_busy #(.N_PHYS(N_PHYS)) u_busy (
      .clk(clk), .rst_n(rst_n), .set_m(set_m), .clr_m(clr_m), .busy_o(busy)
   );

   // issue decision
   logic          lda_bz, ldb_bz, unl_bz, mul_bz, as_bz, unit_ok;
   logic [PW-1:0] px, py, pz;
   logic          sx, sy_eff;

   assign px     = map_q[ins.x];
   assign py     = map_q[ins.y];
   assign pz     = map_q[ins.z];
   assign sx     = sgn_q[ins.x];
   assign sy_eff = sgn_q[ins.y] ^ (ins.op == OP_SUB);

   always_comb begin
      need    = '0;
      unit_ok = 1'b1;
      case (ins.op)
         OP_LDA:  begin need = oh(px);         unit_ok = !lda_bz;            end
         OP_LDB:  begin need = oh(px);         unit_ok = !ldb_bz;            end
         OP_LDAB: begin need = oh(px) | oh(py); unit_ok = !lda_bz && !ldb_bz; end
         OP_UNL:  begin need = oh(px);         unit_ok = !unl_bz;            end
         OP_MUL:  begin need = oh(px) | oh(py) | oh(pz); unit_ok = !mul_bz;  end
         OP_ADD, OP_SUB: begin
            need    = oh(px) | oh(py) | oh(pz) | oh(shadow_q);
            unit_ok = !as_bz;
         end
         default: ;
      endcase
   end

   assign issue = ins_valid && unit_ok && ((need & busy) == '0);
   assign set_m = issue ? need : '0;
   assign clr_m = (lda_done ? lda_pm : '0) | (ldb_done ? ldb_pm : '0) |
                  (unl_done ? unl_pm : '0) | (mul_done ? mul_pm : '0) |
                  (as_done  ? as_pm  : '0);

   // in-flight context
   logic [LREG_W-1:0] lda_l, ldb_l, mul_l, as_l;
   logic              mul_sgn, as_sa, as_sbe;
   logic [SW-1:0]     mul_sum;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lda_start <= 1'b0; ldb_start <= 1'b0; unl_start <= 1'b0;
         mul_start <= 1'b0; as_start  <= 1'b0;
         lda_phys  <= '0; ldb_phys <= '0; unl_phys <= '0;
         unl_sign  <= 1'b0; unl_size <= '0;
         opa_size  <= '0; opb_size <= '0;
         mul_pa    <= '0; mul_pb <= '0; mul_pd <= '0;
         as_pa     <= '0; as_pb <= '0; as_pd <= '0; as_ps <= '0;
         as_sub_eff <= 1'b0;
         lda_bz <= 1'b0; ldb_bz <= 1'b0; unl_bz <= 1'b0; mul_bz <= 1'b0; as_bz <= 1'b0;
         lda_pm <= '0; ldb_pm <= '0; unl_pm <= '0; mul_pm <= '0; as_pm <= '0;
         lda_l  <= '0; ldb_l <= '0; mul_l <= '0; as_l <= '0;
         mul_sgn <= 1'b0; mul_sum <= '0; as_sa <= 1'b0; as_sbe <= 1'b0;
      end else begin
         lda_start <= 1'b0; ldb_start <= 1'b0; unl_start <= 1'b0;
         mul_start <= 1'b0; as_start  <= 1'b0;
         if (lda_done) lda_bz <= 1'b0;
         if (ldb_done) ldb_bz <= 1'b0;
         if (unl_done) unl_bz <= 1'b0;
         if (mul_done) mul_bz <= 1'b0;
         if (as_done)  as_bz  <= 1'b0;
         if (issue) begin
            case (ins.op)
               OP_LDA, OP_LDAB: begin
                  lda_start <= 1'b1; lda_phys <= px; lda_l <= ins.x;
                  lda_pm <= oh(px); lda_bz <= 1'b1;
                  if (ins.op == OP_LDAB) begin
                     ldb_start <= 1'b1; ldb_phys <= py; ldb_l <= ins.y;
                     ldb_pm <= oh(py); ldb_bz <= 1'b1;
                  end
               end
               OP_LDB: begin
                  ldb_start <= 1'b1; ldb_phys <= px; ldb_l <= ins.x;
                  ldb_pm <= oh(px); ldb_bz <= 1'b1;
               end
               OP_UNL: begin
                  unl_start <= 1'b1; unl_phys <= px;
                  unl_sign <= sx; unl_size <= sz_q[ins.x];
                  unl_pm <= need; unl_bz <= 1'b1;
               end
               OP_MUL: begin
                  mul_start <= 1'b1; mul_pa <= px; mul_pb <= py; mul_pd <= pz;
                  opa_size <= sz_q[ins.x]; opb_size <= sz_q[ins.y];
                  mul_l <= ins.z; mul_sgn <= sx ^ sgn_q[ins.y];
                  mul_sum <= SW'(sz_q[ins.x]) + SW'(sz_q[ins.y]);
                  mul_pm <= need; mul_bz <= 1'b1;
               end
               OP_ADD, OP_SUB: begin
                  as_start <= 1'b1; as_pa <= px; as_pb <= py; as_pd <= pz;
                  as_ps <= shadow_q; as_sub_eff <= sx ^ sy_eff;
                  opa_size <= sz_q[ins.x]; opb_size <= sz_q[ins.y];
                  as_l <= ins.z; as_sa <= sx; as_sbe <= sy_eff;
                  as_pm <= need; as_bz <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // completion: result metadata
   logic [SW-1:0] mul_full;
   logic [LW-1:0] mul_fin, as_fin;
   logic          mul_ovf, as_ovf, as_sgn_raw;

   assign mul_full   = mul_sum - SW'(mul_top_zero);
   assign mul_ovf    = mul_full > SW'(MAX_LIMBS);
   assign mul_fin    = mul_ovf ? LW'(MAX_LIMBS) : mul_full[LW-1:0];
   assign as_ovf     = as_res_size > SW'(MAX_LIMBS);
   assign as_fin     = as_ovf ? LW'(MAX_LIMBS) : as_res_size[LW-1:0];
   assign as_sgn_raw = (as_sub_eff && as_pick_shadow) ? as_sbe : as_sa;
   assign swap_en    = as_done && as_sub_eff && as_pick_shadow;

   always_comb begin
      wr_en  = {as_done, mul_done, ldb_done, lda_done};
      wr_l   = {as_l, mul_l, ldb_l, lda_l};
      wr_sz  = {as_fin, mul_fin, ldb_size, lda_size};
      wr_sgn = {as_sgn_raw && (as_fin != '0), mul_sgn && (mul_fin != '0),
                ldb_sign, lda_sign};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) overflow <= 1'b0;
      else if ((mul_done && mul_ovf) || (as_done && as_ovf)) overflow <= 1'b1;
   end

endmodule

// File: rtl/mpcu_chk.sv
module mpcu_chk #(
   parameter int MAX_LIMBS = 512,
   parameter int PW        = 5,
   parameter int LW        = 10
) (
   input logic          clk,
   input logic          rst_n,
   input logic          lda_start,
   input logic          lda_done,
   input logic          unl_start,
   input logic [LW-1:0] unl_size,
   input logic          mul_start,
   input logic          mul_done,
   input logic          as_start,
   input logic          as_done,
   input logic [PW-1:0] as_pd,
   input logic [PW-1:0] as_ps,
   input logic          overflow
);

   logic mul_out, as_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_out <= 1'b0;
         as_out  <= 1'b0;
      end else begin
         if (mul_start)     mul_out <= 1'b1;
         else if (mul_done) mul_out <= 1'b0;
         if (as_start)      as_out  <= 1'b1;
         else if (as_done)  as_out  <= 1'b0;
      end
   end

   // R11
   mul_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |-> !mul_out);
   // R11
   as_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      as_start |-> !as_out);
   // R11
   lda_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lda_start && !lda_done |=> !lda_start);
   // R9
   shadow_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      as_start |-> as_pd != as_ps);
   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   // R10
   unl_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unl_start |-> unl_size <= LW'(MAX_LIMBS));

endmodule

bind mpcu_ctrl mpcu_chk #(.MAX_LIMBS(MAX_LIMBS), .PW(PW), .LW(LW)) u_chk (
   .clk(clk), .rst_n(rst_n), .lda_start(lda_start), .lda_done(lda_done),
   .unl_start(unl_start), .unl_size(unl_size), .mul_start(mul_start),
   .mul_done(mul_done), .as_start(as_start), .as_done(as_done),
   .as_pd(as_pd), .as_ps(as_ps), .overflow(overflow)
);

// File: tb/mpcu_ctrl_bench.sv
module mpcu_ctrl_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       prog_valid = 1'b0;
   logic [7:0] prog_byte = 8'h00;
   logic       prog_ready;
   logic       lda_start, ldb_start, unl_start, mul_start, as_start;
   logic [4:0] lda_phys, ldb_phys, unl_phys, mul_pa, mul_pb, mul_pd;
   logic [4:0] as_pa, as_pb, as_pd, as_ps;
   logic       unl_sign, as_sub_eff, overflow;
   logic [9:0] unl_size, opa_size, opb_size;
   logic       lda_done = 1'b0, ldb_done = 1'b0, unl_done = 1'b0;
   logic       mul_done = 1'b0, as_done = 1'b0;
   logic       lda_sign = 1'b0, ldb_sign = 1'b0, mul_top_zero = 1'b0, as_pick_shadow = 1'b0;
   logic [9:0] lda_size = '0, ldb_size = '0;
   logic [10:0] as_res_size = '0;

   mpcu_ctrl u_mpcu_ctrl (.*);

   int checks = 0, fails = 0, cyc = 0;
   localparam int LIMIT = 20000;

   logic [10:0] hdr_a[$], hdr_b[$];
   logic        mul_q[$];
   logic [11:0] as_q[$];
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stub units
   int a_cnt = 0, b_cnt = 0, u_cnt = 0, m_cnt = 0, s_cnt = 0;
   always @(posedge clk) begin
      lda_done <= 1'b0; ldb_done <= 1'b0; unl_done <= 1'b0;
      mul_done <= 1'b0; as_done <= 1'b0;
      if (lda_start) a_cnt <= 3;
      else if (a_cnt > 0) begin
         a_cnt <= a_cnt - 1;
         if (a_cnt == 1) begin lda_done <= 1'b1; {lda_sign, lda_size} <= hdr_a.pop_front(); end
      end
      if (ldb_start) b_cnt <= 3;
      else if (b_cnt > 0) begin
         b_cnt <= b_cnt - 1;
         if (b_cnt == 1) begin ldb_done <= 1'b1; {ldb_sign, ldb_size} <= hdr_b.pop_front(); end
      end
      if (unl_start) u_cnt <= 2;
      else if (u_cnt > 0) begin
         u_cnt <= u_cnt - 1;
         if (u_cnt == 1) unl_done <= 1'b1;
      end
      if (mul_start) m_cnt <= 6;
      else if (m_cnt > 0) begin
         m_cnt <= m_cnt - 1;
         if (m_cnt == 1) begin mul_done <= 1'b1; mul_top_zero <= mul_q.pop_front(); end
      end
      if (as_start) s_cnt <= 4;
      else if (s_cnt > 0) begin
         s_cnt <= s_cnt - 1;
         if (s_cnt == 1) begin as_done <= 1'b1; {as_pick_shadow, as_res_size} <= as_q.pop_front(); end
      end
   end

   // monitor
   int n_lda = 0, n_unl = 0, n_mul = 0, n_as = 0;
   logic prev_unl = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (lda_start) begin
            n_lda++;
            if (n_lda == 1) begin
               chk(ldb_start == 1'b1, "R3 load-both strobes", ldb_start, 1);
               chk(lda_phys == 5'd0 && ldb_phys == 5'd1, "R3 load phys", ldb_phys, 1);
            end
         end
         if (mul_start) begin
            n_mul++;
            if (n_mul == 1) begin
               chk(mul_pa == 0 && mul_pb == 1 && mul_pd == 2, "R6 mul phys", mul_pd, 2);
               chk(opa_size == 3 && opb_size == 2, "R7 operand sizes", opb_size, 2);
            end else begin
               chk(overflow == 1'b0, "R10 overflow before", overflow, 0);
            end
         end
         if (as_start) begin
            n_as++;
            case (n_as)
               1: chk(as_sub_eff == 1'b1 && as_ps == 16 && as_pd == 3, "R7 add differ", as_sub_eff, 1);
               2: chk(as_ps == 16 && as_pd == 4, "R9 shadow before swap", as_ps, 16);
               3: chk(as_sub_eff == 1'b1, "R7 sub differ", as_sub_eff, 1);
               4: chk(as_sub_eff == 1'b0 && as_ps == 4, "R7 sub agree / R9 new shadow", as_ps, 4);
               default: chk(as_ps == 4 && as_pd == 7, "R9 second swap", as_pd, 7);
            endcase
         end
         if (unl_start) begin
            logic [15:0] e;
            string t;
            n_unl++;
            chk(!prev_unl, "R11 one-cycle strobe", prev_unl, 0);
            if (n_unl == 3) chk(m_cnt == 0, "R5 unload waits for multiply", m_cnt, 0);
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected unload", unl_phys, -1);
            else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(unl_phys == e[15:11], {t, " phys"}, unl_phys, e[15:11]);
               chk(unl_sign == e[10], {t, " sign"}, unl_sign, e[10]);
               chk(unl_size == e[9:0], {t, " size"}, unl_size, e[9:0]);
            end
         end
         prev_unl <= unl_start;
      end
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      prog_valid = 1'b1;
      prog_byte  = b;
      while (!prog_ready && cyc < LIMIT) @(negedge clk);
      @(negedge clk);
      prog_valid = 1'b0;
   endtask

   task automatic expect_unl(input int phys, input bit s, input int sz, input string t);
      exp_q.push_back({5'(phys), s, 10'(sz)});
      tag_q.push_back(t);
   endtask

   initial begin
      hdr_a = '{ {1'b0, 10'd3}, {1'b0, 10'd400} };
      hdr_b = '{ {1'b1, 10'd2}, {1'b1, 10'd300} };
      mul_q = '{ 1'b1, 1'b0 };
      as_q  = '{ {1'b0, 11'd3}, {1'b1, 11'd2}, {1'b0, 11'd0}, {1'b1, 11'd3}, {1'b1, 11'd1} };

      repeat (3) @(negedge clk);
      // R1 reset state
      chk(prog_ready == 1'b1, "R1 ready", prog_ready, 1);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);
      chk(!(lda_start | ldb_start | unl_start | mul_start | as_start), "R1 strobes", 1, 0);
      rst_n = 1'b1;

      expect_unl(0, 0, 3, "R4 unload r0");
      expect_unl(1, 1, 2, "R1 identity map r1");
      expect_unl(2, 1, 4, "R6 product");
      expect_unl(3, 0, 3, "R8 differ no pick");
      expect_unl(16, 0, 2, "R9 swap to shadow");
      expect_unl(5, 0, 0, "R8 zero positive");
      expect_unl(6, 1, 3, "R9 pick ignored");
      expect_unl(4, 0, 1, "R9 second swap");
      expect_unl(10, 1, 512, "R10 clamp");

      send(8'h60); send(8'h01);                 // load both r0, r1
      send(8'h80); send(8'h00);                 // unload r0
      send(8'h80); send(8'h10);                 // unload r1
      send(8'hA0); send(8'h01); send(8'h20);    // mul r0,r1 -> r2
      send(8'h80); send(8'h20);
      send(8'hC0); send(8'h01); send(8'h30);    // add r0,r1 -> r3
      send(8'h80); send(8'h30);
      send(8'hC0); send(8'h10); send(8'h40);    // add r1,r0 -> r4
      send(8'h80); send(8'h40);
      send(8'hE0); send(8'h00); send(8'h50);    // sub r0,r0 -> r5
      send(8'h80); send(8'h50);
      send(8'hE0); send(8'h10); send(8'h60);    // sub r1,r0 -> r6
      send(8'h80); send(8'h60);
      send(8'hC0); send(8'h10); send(8'h70);    // add r1,r0 -> r7
      send(8'h80); send(8'h70);
      send(8'h00);                              // R2 nop
      send(8'h20); send(8'h80);                 // load A r8
      send(8'h40); send(8'h90);                 // load B r9
      send(8'hA0); send(8'h89); send(8'hA0);    // mul r8,r9 -> r10
      send(8'h80); send(8'hA0);

      while (exp_q.size() > 0 && cyc < LIMIT) @(negedge clk);
      repeat (4) @(negedge clk);
      if (cyc >= LIMIT) chk(1'b0, "R5 watchdog expired", cyc, LIMIT);
      chk(exp_q.size() == 0, "R2 all unloads seen", exp_q.size(), 0);
      chk(overflow == 1'b1, "R10 overflow sticky", overflow, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule